// File: doc/BRIEF.md
# Banked-register OR execute unit

This block carries out the two inclusive-OR instructions of a small 8-bit accumulator core. One form ORs an 8-bit literal taken from the instruction word into the working register. The other form ORs the working register with a location in an on-block register file. It writes the result either to the working register or back to that location. Both forms update only the negative and zero flags.

Every instruction spends one instruction cycle of four clock phases. The phases are: latch and decode the word, fetch the operand, compute, and commit. A free-running 2-bit phase counter paces the work, and the current phase is visible on a port. The register-file address comes from one of two sources. One is the access bank: low offsets land in bank 0, and high offsets land in the highest-numbered bank. The other is a bank-select input, concatenated above the 8-bit offset. A load port and an asynchronous read port give the surrounding logic direct access to the register file.

Top module: `or_exec_unit`

## Requirements
- R1: An instruction word whose upper byte is 09h sets the working register to its old value ORed with the lower byte of the word.
- R2: An instruction word whose top six bits are 000100 uses bit 9 as destination d, bit 8 as bank mode a and bits 7:0 as offset f. With d=0 the OR of the working register and the addressed location goes to the working register, and the location keeps its value.
- R3: In the register form with d=1 the OR result is written into the addressed location, and the working register keeps its value.
- R4: With a=0 an offset below 80h addresses bank 0 and an offset of 80h or above addresses the highest bank; the bank-select input has no effect.
- R5: With a=1 the location is {bank_sel, f}.
- R6: After either OR instruction, n_flag equals bit 7 of the result and z_flag is 1 exactly when the result is 00h.
- R7: The phase output steps 0,1,2,3,0 on successive clocks. Working register, flags and file change only at the edge that ends phase 3.
- R8: Any other instruction word leaves the working register, both flags and the register file unchanged.
- R9: Reset clears the phase, the working register and both flags; the register file is not cleared.
- R10: ld_we writes ld_data to ld_addr at a clock edge. When an instruction commit writes the same cycle, the commit wins.
- R11: The instruction word is sampled only at the edge that ends phase 0; changes during phases 1 to 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr | input | 16 | Instruction word, sampled at end of phase 0 |
| bank_sel | input | BANK_W | Bank-select value used when a=1 |
| ld_we | input | 1 | Register-file load enable |
| ld_addr | input | BANK_W+8 | Register-file load address |
| ld_data | input | 8 | Register-file load data |
| rd_addr | input | BANK_W+8 | Register-file read address |
| rd_data | output | 8 | Register-file read data (combinational) |
| phase | output | 2 | Current phase of the instruction cycle |
| wreg | output | 8 | Working register |
| n_flag | output | 1 | Negative flag |
| z_flag | output | 1 | Zero flag |

## Verification
The bench uses the default BANK_W of 2, which gives four banks of 256 locations. With that value the high half of the access bank is bank 3, and bank 1 can be reached only through the bank-select path. So the same offset A0h hits different locations under a=0 and a=1, and a write through one mode can be seen not to touch the other. The small file also keeps a full-width model of the addressing affordable at elaboration.

// File: rtl/or_exec_unit.sv
module or_exec_unit #(
  parameter int BANK_W = 2,
  localparam int AW = BANK_W + 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       instr,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              ld_we,
  input  logic [AW-1:0]     ld_addr,
  input  logic [7:0]        ld_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_data,
  output logic [1:0]        phase,
  output logic [7:0]        wreg,
  output logic              n_flag,
  output logic              z_flag
);

  localparam logic [1:0] PH_DEC = 2'd0;
  localparam logic [1:0] PH_RD  = 2'd1;
  localparam logic [1:0] PH_EX  = 2'd2;
  localparam logic [1:0] PH_WR  = 2'd3;

  logic [7:0]    mem [DEPTH];
  logic [1:0]    ph;
  logic [15:0]   ir;
  logic [7:0]    opnd;
  logic [7:0]    res;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] eff_addr;

  wire       is_lit = (ir[15:8] == 8'h09);
  wire       is_reg = (ir[15:10] == 6'b000100);
  wire       legal  = is_lit | is_reg;
  wire       dst_f  = ir[9];
  wire       bmode  = ir[8];
  wire [7:0] ofs    = ir[7:0];
  wire       wr_w   = is_lit | (is_reg & ~dst_f);
  wire       wr_f   = is_reg & dst_f;

  assign eff_addr = bmode ? {bank_sel, ofs} : {{BANK_W{ofs[7]}}, ofs};
  assign rd_data  = mem[rd_addr];
  assign phase    = ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_DEC;
    else        ph <= ph + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir     <= '0;
      opnd   <= '0;
      res    <= '0;
      addr_q <= '0;
      wreg   <= '0;
      n_flag <= 1'b0;
      z_flag <= 1'b0;
    end else begin
      case (ph)
        PH_DEC: ir <= instr;
        PH_RD: begin
          addr_q <= eff_addr;
          opnd   <= is_lit ? ofs : mem[eff_addr];
        end
        PH_EX: res <= wreg | opnd;
        PH_WR: if (legal) begin
          if (wr_w) wreg <= res;
          n_flag <= res[7];
          z_flag <= (res == 8'h00);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (ph == PH_WR && wr_f) mem[addr_q] <= res;
    else if (ld_we)          mem[ld_addr] <= ld_data;
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ph == $past(ph) + 2'd1)); // R7
  AST_WREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_WR) |=> $stable(wreg) && $stable(n_flag) && $stable(z_flag)); // R7
  AST_FLAG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WR && legal) |=> (n_flag == $past(res[7])) && (z_flag == ($past(res) == 8'h00))); // R6
  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WR && !legal) |=> $stable(wreg) && $stable(n_flag) && $stable(z_flag)); // R8
  AST_FILE_DEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WR && wr_f) |=> $stable(wreg)); // R3
  AST_ACCESS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_EX && is_reg && !bmode) |-> (addr_q[AW-1:8] == '0) || (addr_q[AW-1:8] == '1)); // R4

endmodule

// File: tb/test_or_exec_unit.sv
module test_or_exec_unit;
  localparam int CLK_PERIOD = 10;
  localparam int BANK_W = 2;
  localparam int AW = BANK_W + 8;
  localparam int NV = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic [BANK_W-1:0] bank_sel = '0;
  logic ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] phase;
  logic [7:0] wreg;
  logic n_flag, z_flag;

  int errors = 0;
  int checks = 0;

  or_exec_unit #(.BANK_W(BANK_W)) i_or_exec_unit (
    .clk, .rst_n, .instr, .bank_sel, .ld_we, .ld_addr, .ld_data,
    .rd_addr, .rd_data, .phase, .wreg, .n_flag, .z_flag);

  always #(CLK_PERIOD/2) clk = ~clk;

  // instr, bank_sel, probe address, expected probe data, expected wreg, N, Z
  localparam logic [45:0] VEC [NV] = '{
    {16'h0913, 2'd0, 10'h005, 8'h91, 8'h13, 1'b0, 1'b0},  // R1
    {16'h1005, 2'd0, 10'h005, 8'h91, 8'h93, 1'b1, 1'b0},  // R2, R6
    {16'h12A0, 2'd1, 10'h3A0, 8'hD3, 8'h93, 1'b1, 1'b0},  // R3, R4
    {16'h12A0, 2'd1, 10'h1A0, 8'h02, 8'h93, 1'b1, 1'b0},  // R4 bank 1 untouched
    {16'h13A0, 2'd1, 10'h1A0, 8'h93, 8'h93, 1'b1, 1'b0},  // R5
    {16'hFFFF, 2'd1, 10'h1A0, 8'h93, 8'h93, 1'b1, 1'b0},  // R8
    {16'h1400, 2'd0, 10'h000, 8'h00, 8'h93, 1'b1, 1'b0}   // R8
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    instr = 16'h0000;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic preload(input logic [AW-1:0] a, input logic [7:0] d);
    ld_we = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic exec(input logic [15:0] w, input logic [BANK_W-1:0] b);
    while (phase != 2'd0) @(negedge clk);
    instr = w; bank_sel = b;
    @(negedge clk);
    instr = 16'h0000;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    chk("R9 phase", phase, 0);
    chk("R9 wreg", wreg, 0);
    chk("R9 flags", {n_flag, z_flag}, 0);

    preload(10'h005, 8'h91);
    preload(10'h3A0, 8'h40);
    preload(10'h1A0, 8'h02);
    preload(10'h010, 8'h00);
    preload(10'h020, 8'h04);

    for (int i = 0; i < NV; i++) begin
      exec(VEC[i][45:30], VEC[i][29:28]);
      rd_addr = VEC[i][27:18];
      #1;
      chk("R1-table file", rd_data, VEC[i][17:10]);
      chk("R2-table wreg", wreg, VEC[i][9:2]);
      chk("R6 table flags", {n_flag, z_flag}, VEC[i][1:0]);
    end

    // R9: file survives reset; R6 zero result
    do_reset();
    rd_addr = 10'h005; #1;
    chk("R9 file kept", rd_data, 8'h91);
    exec(16'h0900, '0);
    chk("R6 zero wreg", wreg, 0);
    chk("R6 zero flags", {n_flag, z_flag}, 2'b01);
    exec(16'h1010, '0);
    chk("R2 zero wreg", wreg, 0);
    chk("R6 zero reg form", {n_flag, z_flag}, 2'b01);

    // R1 worked example
    exec(16'h099A, '0);
    chk("R1 wreg 9A", wreg, 8'h9A);
    exec(16'h0935, '0);
    chk("R1 wreg BF", wreg, 8'hBF);
    chk("R6 flags BF", {n_flag, z_flag}, 2'b10);

    // R7: phase walk and commit timing
    while (phase != 2'd0) @(negedge clk);
    instr = 16'h0940;
    for (int p = 1; p <= 3; p++) begin
      @(negedge clk);
      instr = 16'h0000;
      chk("R7 phase", phase, p);
      chk("R7 wreg held", wreg, 8'hBF);
    end
    @(negedge clk);
    chk("R7 phase wrap", phase, 0);
    chk("R7 commit", wreg, 8'hFF);

    // R11: mid-cycle change ignored
    do_reset();
    instr = 16'h0901;
    @(negedge clk);
    instr = 16'h09FF;
    repeat (3) @(negedge clk);
    instr = 16'h0000;
    chk("R11 wreg", wreg, 8'h01);

    // R10: commit beats load on same address; R3 wreg kept
    while (phase != 2'd0) @(negedge clk);
    instr = 16'h1220;
    @(negedge clk);
    instr = 16'h0000;
    repeat (2) @(negedge clk);
    ld_we = 1'b1; ld_addr = 10'h020; ld_data = 8'h55;
    @(negedge clk);
    ld_we = 1'b0;
    rd_addr = 10'h020; #1;
    chk("R10 commit wins", rd_data, 8'h05);
    chk("R3 wreg kept", wreg, 8'h01);
    preload(10'h020, 8'h66);
    rd_addr = 10'h020; #1;
    chk("R10 load", rd_data, 8'h66);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule